// File: doc/BRIEF.md
# Port Configuration Lock Key Sequencer

This block holds the lock control word of a general-purpose I/O port. Software picks which pins to protect by writing a per-pin mask in the low half of the word, and then proves intent by writing a key bit three times in a fixed pattern: set, clear, set. Every one of those writes must be a full 32-bit word and must carry the same mask. When the third write lands, the key latches. From then on the mask is applied to the port's configuration register file. That file stops accepting writes to the mode, output type, speed, pull and alternate-function fields of every masked pin until the next reset.

Any wrong step sends the tracker back to idle. A wrong step is a key value out of order, a mask that differs from the one captured at the first write, or a byte or half-word access to the register. A wrong step that itself carries key = 1 starts a new attempt at once. Reads and accesses to other addresses leave the tracker untouched. Once the key has latched, the whole register ignores writes.

Top module: `lock_key_seq`

## Requirements
- R1: After reset the key bit reads 0, the mask reads 0 and `lock_mask` is 0.
- R2: A read at offset 0x1C returns the mask in bits 15:0 and the key in bit 16, with bits 31:17 at 0. Any other offset reads 0.
- R3: While the key is 0, a word write (`bus_size` = 2) at offset 0x1C stores data bits 15:0 as the mask. `lock_mask` stays 0 while the key is 0.
- R4: Three word writes at offset 0x1C carry key (data bit 16) values 1, 0, 1 in that order and the same mask each time. After the edge of the third write, the key reads 1 and `lock_mask` equals that mask.
- R5: If the second or third write of the pattern carries a mask different from the first, the key does not latch.
- R6: A byte (`bus_size` = 0) or half-word (`bus_size` = 1) write at offset 0x1C aborts the pattern and does not change the stored mask.
- R7: A key value out of order returns the tracker to idle. A write with key = 1 at any unlatched step starts a new attempt with its own mask.
- R8: Reads, and writes to any offset other than 0x1C, do not change the tracker's progress, the mask or the key.
- R9: Once the key has latched, it stays 1 and the mask and `lock_mask` stay unchanged under every write, until reset.
- R10: Reset clears a latched key and releases `lock_mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_size | input | 2 | Access size: 0 byte, 1 half-word, 2 word |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| lock_mask | output | 16 | Per-pin freeze mask for the configuration register file |

## Verification
The bench targets the places where a sequencer goes quietly wrong. A mask that changes between steps must not arm, or the wrong pins get frozen. A half-word write in the middle must abort, or a narrow store could complete the pattern. A repeated key = 1 must restart the attempt and not simply fail, or valid software retries would be refused. Accesses to other offsets in between must not reset progress, or locking would become unreliable under concurrent bus traffic. After the lock latches, every kind of write must bounce off. A design that got any of these wrong shows up as a wrong key bit, a wrong mask read-back or a wrong `lock_mask` at the sample after the offending write. Seeded random traffic biased toward near-correct patterns catches the same failures in mixed orders.

// File: rtl/lockseq_pkg.sv
package lockseq_pkg;
  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_HALF = 2'd1,
    ACC_WORD = 2'd2
  } acc_size_e;

  typedef enum logic [1:0] {
    SEQ_IDLE    = 2'd0,
    SEQ_GOT_SET = 2'd1,
    SEQ_GOT_CLR = 2'd2,
    SEQ_ARMED   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/lockseq_decode.sv
module lockseq_decode
  import lockseq_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h1C
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic              hit,
  output logic              word_wr,
  output logic              part_wr
);
  always_comb begin
    hit     = (addr == REG_OFFSET);
    word_wr = wr_en && hit && (size == ACC_WORD);
    part_wr = wr_en && hit && (size != ACC_WORD);
  end
endmodule

// File: rtl/lockseq_fsm.sv
module lockseq_fsm
  import lockseq_pkg::*;
#(
  parameter int unsigned PINS = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            word_wr,
  input  logic            part_wr,
  input  logic            key_in,
  input  logic [PINS-1:0] mask_in,
  output logic            armed
);
  seq_state_e      state_q, state_d;
  logic [PINS-1:0] cand_q;
  logic            cand_en;
  logic            same_mask;

  assign same_mask = (mask_in == cand_q);

  always_comb begin
    state_d = state_q;
    cand_en = 1'b0;
    case (state_q)
      SEQ_IDLE: begin
        if (word_wr && key_in) begin
          state_d = SEQ_GOT_SET;
          cand_en = 1'b1;
        end
      end
      SEQ_GOT_SET: begin
        if (part_wr) begin
          state_d = SEQ_IDLE;
        end else if (word_wr) begin
          if (key_in) begin
            state_d = SEQ_GOT_SET;
            cand_en = 1'b1;
          end else if (same_mask) begin
            state_d = SEQ_GOT_CLR;
          end else begin
            state_d = SEQ_IDLE;
          end
        end
      end
      SEQ_GOT_CLR: begin
        if (part_wr) begin
          state_d = SEQ_IDLE;
        end else if (word_wr) begin
          if (key_in && same_mask) begin
            state_d = SEQ_ARMED;
          end else if (key_in) begin
            state_d = SEQ_GOT_SET;
            cand_en = 1'b1;
          end else begin
            state_d = SEQ_IDLE;
          end
        end
      end
      default: state_d = SEQ_ARMED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q <= '0;
    end else if (cand_en) begin
      cand_q <= mask_in;
    end
  end

  assign armed = (state_q == SEQ_ARMED);
endmodule

// File: rtl/lock_key_seq.sv
module lock_key_seq
  import lockseq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PINS   = 16,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h1C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [1:0]        bus_size,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [PINS-1:0]   lock_mask
);
  localparam int unsigned KEY_POS = PINS;
  localparam int unsigned PAD_W   = DATA_W - PINS - 1;

  logic            hit, word_wr, part_wr;
  logic            armed_q;
  logic [PINS-1:0] mask_q, mask_d;
  logic            mask_en;

  lockseq_decode #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_dec (
    .wr_en   (bus_wr),
    .addr    (bus_addr),
    .size    (bus_size),
    .hit     (hit),
    .word_wr (word_wr),
    .part_wr (part_wr)
  );

  lockseq_fsm #(.PINS(PINS)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .word_wr (word_wr),
    .part_wr (part_wr),
    .key_in  (bus_wdata[KEY_POS]),
    .mask_in (bus_wdata[PINS-1:0]),
    .armed   (armed_q)
  );

  always_comb begin
    mask_en = word_wr && !armed_q;
    mask_d  = bus_wdata[PINS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  for (genvar g = 0; g < PINS; g++) begin : g_pin_gate
    assign lock_mask[g] = armed_q & mask_q[g];
  end

  assign bus_rdata = hit ? {{PAD_W{1'b0}}, armed_q, mask_q} : '0;
endmodule

// File: rtl/lock_key_seq_chk.sv
module lock_key_seq_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned PINS   = 16,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h1C
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_size,
  input logic              key_bit,
  input logic              armed,
  input logic [PINS-1:0]   mask,
  input logic [PINS-1:0]   lock_mask
);
  // R9: latched key never drops before reset
  p_key_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed);

  // R9: mask and applied mask frozen once latched
  p_mask_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> ($stable(mask) && $stable(lock_mask)));

  // R4: the key can only latch on a full-word key=1 write at the register
  p_arm_on_key_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(bus_wr && bus_addr == REG_OFFSET && bus_size == 2'd2 && key_bit));

  // R6: narrow write neither latches the key nor changes the mask
  p_subword_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == REG_OFFSET && bus_size != 2'd2 && !armed) |=> (!armed && $stable(mask)));

  // R8: writes elsewhere leave the register alone
  p_other_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr != REG_OFFSET) |=> ($stable(mask) && $stable(armed)));
endmodule

bind lock_key_seq lock_key_seq_chk #(
  .ADDR_W(ADDR_W), .PINS(PINS), .REG_OFFSET(REG_OFFSET)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_size  (bus_size),
  .key_bit   (bus_wdata[PINS]),
  .armed     (armed_q),
  .mask      (mask_q),
  .lock_mask (lock_mask)
);

// File: tb/lock_key_seq_test.sv
module lock_key_seq_test;
  localparam logic [7:0] OFF = 8'h1C;

  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [1:0]  bus_size;
  logic [31:0] bus_rdata;
  logic [15:0] lock_mask;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  // bench model, written from the requirements
  int          m_state;   // 0 idle, 1 after set, 2 after clear
  logic [15:0] m_cand;
  logic [15:0] m_mask;
  bit          m_armed;

  lock_key_seq uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_size(bus_size), .bus_rdata(bus_rdata),
    .lock_mask(lock_mask)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] exp_word();
    return {15'b0, m_armed, m_mask};
  endfunction

  function automatic logic [15:0] exp_lock();
    return m_armed ? m_mask : 16'h0;
  endfunction

  task automatic model_reset();
    m_state = 0; m_cand = '0; m_mask = '0; m_armed = 0;
  endtask

  task automatic model_write(input logic [7:0] a, input logic [31:0] d, input logic [1:0] s);
    logic k;
    logic [15:0] mk;
    if (a != OFF || m_armed) return;
    if (s != 2'd2) begin m_state = 0; return; end
    k = d[16]; mk = d[15:0];
    m_mask = mk;
    if (k && m_state == 2 && mk == m_cand) begin
      m_armed = 1;
    end else if (k) begin
      m_state = 1; m_cand = mk;
    end else if (m_state == 1 && mk == m_cand) begin
      m_state = 2;
    end else begin
      m_state = 0;
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    bus_addr = OFF;
    #1;
    chk({tag, " read-back"}, bus_rdata, exp_word());
    chk({tag, " lock_mask"}, {16'h0, lock_mask}, {16'h0, exp_lock()});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_wr = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [1:0] s);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_size = s;
    @(negedge clk);
    bus_wr = 1'b0;
    model_write(a, d, s);
  endtask

  task automatic key_wr(input bit k, input logic [15:0] mk);
    wr(OFF, {15'b0, k, mk}, 2'd2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R0 watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; bus_size = 2'd2;
    void'($urandom(32'd20240611));
    do_reset();

    // R1 reset state
    check_all("R1");

    // R2 other offsets read zero, reserved bits zero
    bus_addr = 8'h18; #1;
    chk("R2 other offset", bus_rdata, 32'h0);
    key_wr(0, 16'hFFFF);
    check_all("R2 reserved bits");

    // R3 mask store while unlocked
    key_wr(0, 16'h1234);
    check_all("R3");

    // R4 correct pattern
    key_wr(1, 16'h00F0);
    key_wr(0, 16'h00F0);
    check_all("R4 before third write");
    key_wr(1, 16'h00F0);
    check_all("R4 latched");

    // R9 writes ignored once latched
    key_wr(0, 16'hFFFF);
    wr(OFF, 32'h0000_0F0F, 2'd1);
    key_wr(1, 16'h0001); key_wr(0, 16'h0001); key_wr(1, 16'h0001);
    check_all("R9");

    // R10 reset releases lock
    do_reset();
    check_all("R10");

    // R5 mask mismatch aborts; R7 key=1 restarts
    key_wr(1, 16'hAAAA);
    key_wr(0, 16'h5555);
    key_wr(1, 16'h5555);
    check_all("R5 mismatch");
    key_wr(0, 16'h5555);
    key_wr(1, 16'h5555);
    check_all("R7 restart after abort");
    do_reset();

    // R5 mismatch at the third step
    key_wr(1, 16'h0102); key_wr(0, 16'h0102); key_wr(1, 16'h0103);
    check_all("R5 third step");
    do_reset();

    // R6 half-word write aborts and keeps mask
    key_wr(1, 16'h0C0C);
    wr(OFF, 32'h0000_3333, 2'd1);
    check_all("R6 half keeps mask");
    key_wr(1, 16'h0C0C);
    check_all("R6 no latch");
    key_wr(0, 16'h0C0C);
    wr(OFF, 32'h0001_0C0C, 2'd0);
    key_wr(1, 16'h0C0C);
    check_all("R6 byte abort");
    do_reset();

    // R7 repeated set restarts, double clear aborts
    key_wr(1, 16'h0011); key_wr(1, 16'h0022); key_wr(0, 16'h0022); key_wr(1, 16'h0022);
    check_all("R7 double set");
    do_reset();
    key_wr(1, 16'h0044); key_wr(0, 16'h0044); key_wr(0, 16'h0044); key_wr(1, 16'h0044);
    check_all("R7 double clear");
    do_reset();

    // R8 foreign traffic and reads between steps
    key_wr(1, 16'h8001);
    wr(8'h14, 32'h0000_FFFF, 2'd2);
    bus_addr = OFF; #1;
    chk("R8 read mid-pattern", bus_rdata, exp_word());
    key_wr(0, 16'h8001);
    wr(8'h00, 32'h0001_0000, 2'd0);
    key_wr(1, 16'h8001);
    check_all("R8 latched through traffic");
    do_reset();

    // random traffic, R4 R5 R6 R7 R8 R9 against the model
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [15:0] mk;
      bit k;
      if (i % 150 == 149) do_reset();
      r  = $urandom % 20;
      mk = ($urandom % 4 == 0) ? 16'($urandom) : (($urandom % 2) ? 16'hA5A5 : 16'h0F0F);
      if (r < 2) begin
        wr(8'($urandom % 8) * 8'h4, $urandom, 2'($urandom % 3));
      end else if (r < 3) begin
        wr(OFF, $urandom, 2'($urandom % 2));
      end else begin
        k = ($urandom % 4 == 0) ? 1'($urandom) : (m_state != 1);
        if (m_state != 0 && ($urandom % 4 != 0)) mk = m_cand;
        key_wr(k, mk);
      end
      check_all("R8 random");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule